// File: doc/BRIEF.md
# Board Interrupt and Control Registers

This block is the register file of a development board's glue logic. It gathers sixteen external interrupt lines into a single level interrupt for the processor. Each line can latch a pending bit, subject to an enable register. The same register window also holds scratch registers for LEDs, switches and miscellaneous board control, plus two card-slot registers. Each slot register reports card presence from a dedicated interrupt line and exposes five writable control bits.

Software talks to the block over a simple 32-bit register bus: an address within a 1 MB window, a write enable and write data. Read data comes back one clock later. The processor receives `irqOut`, which stays high while any enabled pending bit is set. Software clears pending bits by writing the pending register.

Top module: `board_irq_regs`

## Requirements
- R1: The eight plain registers at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 store a full 32-bit write and read it back unchanged.
- R2: `busRdata` is registered. It shows the register addressed in the previous cycle, with the value that register held before any write made in that same cycle.
- R3: Pending bit i (offset 0xD0, bit i) sets when input line i is 1 in a cycle where it was 0 in the previous cycle and enable bit i is 1. Disabled lines never set a pending bit, and a line held high does not set its bit again.
- R4: A write to the enable register (0xC0) or the pending register (0xD0) stores the write data ANDed with 0x000FEEFF. The pending register is replaced, not cleared bit by bit. A latch in the same cycle as a pending write is ORed onto the written value.
- R5: `irqOut` is 1 exactly one cycle after the AND of the pending and enable registers is nonzero, and 0 one cycle after it is zero.
- R6: Bit 5 of slot register 0 (0xE0) reads as the inverse of line 9, and bit 5 of slot register 1 (0xE4) as the inverse of line 13. The line value is the one sampled one clock earlier.
- R7: A bus write to either slot register changes only bits 4:0. Bit 10 stays 1, bit 5 follows its line, and all other bits stay 0.
- R8: After reset, both slot registers read 0x00000420 while their lines are low, every other register reads 0, and `irqOut` is 0 during reset.
- R9: A read of any undefined offset returns 0, and a write to an undefined offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 20 | Byte offset within the register window |
| busWe | input | 1 | Write strobe for the addressed register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the previous cycle's address |
| irqLines | input | 16 | Raw interrupt input levels |
| irqOut | output | 1 | Level interrupt to the processor |

## Verification
The assertions assume that `irqLines` and the bus inputs are synchronous to `clk` and hold steady through each edge. The bench meets this by changing every input a short delay after the rising edge. The assertions treat `busWe` as a one-cycle strobe and make no assumption about address alignment. For that reason the stimulus also drives unaligned and out-of-map offsets inside the window. It also drives interrupt lines held high across pending writes and rising edges that coincide with pending writes, so that the latch-merge rule is exercised from both sides.

// File: rtl/board_regs_pkg.sv
package board_regs_pkg;

  localparam int NUM_REGS  = 12;
  localparam int NUM_PLAIN = 8;

  typedef enum logic [3:0] {
    REG_LED0    = 4'd0,
    REG_LED1    = 4'd1,
    REG_LEDCTL  = 4'd2,
    REG_SWITCH  = 4'd3,
    REG_MISC0   = 4'd4,
    REG_MISC1   = 4'd5,
    REG_MISC2   = 4'd6,
    REG_MISCIN  = 4'd7,
    REG_INTEN   = 4'd8,
    REG_INTPEND = 4'd9,
    REG_SLOT0   = 4'd10,
    REG_SLOT1   = 4'd11
  } regIdx_e;

  // byte offset of each register inside the window
  function automatic logic [7:0] regOffset(input int idx);
    case (idx)
      0:       return 8'h10;
      1:       return 8'h14;
      2:       return 8'h40;
      3:       return 8'h60;
      4:       return 8'h80;
      5:       return 8'h84;
      6:       return 8'h88;
      7:       return 8'h90;
      8:       return 8'hC0;
      9:       return 8'hD0;
      10:      return 8'hE0;
      default: return 8'hE4;
    endcase
  endfunction

  typedef struct packed {
    logic [NUM_REGS-1:0] wrHot;
    logic [NUM_REGS-1:0] rdHot;
  } strobes_t;

endpackage

// File: rtl/board_regs_ctrl.sv
module board_regs_ctrl
  import board_regs_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobes_t          strb
);

  logic [NUM_REGS-1:0] hitVec;
  logic [NUM_REGS-1:0] wrVec;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign hitVec[g] = (busAddr == ADDR_W'(regOffset(g)));
    assign wrVec[g]  = hitVec[g] & busWe;
  end

  assign strb = '{wrHot: wrVec, rdHot: hitVec};

  // R9
  always_comb begin
    onehot_hit_chk: assert ($onehot0(hitVec));
  end

endmodule

// File: rtl/board_regs_data.sv
module board_regs_data
  import board_regs_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          NUM_IRQ    = 16,
  parameter logic [31:0] PEND_MASK  = 32'h000F_EEFF,
  parameter int          SLOT0_LINE = 9,
  parameter int          SLOT1_LINE = 13,
  parameter int          CTRL_W     = 5,
  parameter int          CD_BIT     = 5,
  parameter int          RDY_BIT    = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [NUM_IRQ-1:0] irqLines,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut
);

  localparam logic [DATA_W-1:0] MASK_W = DATA_W'(PEND_MASK);

  logic [DATA_W-1:0]  plainQ [NUM_PLAIN];
  logic [DATA_W-1:0]  intEn, intPend, pendNext;
  logic [NUM_IRQ-1:0] levelQ, riseVec;
  logic [CTRL_W-1:0]  slotCtl0, slotCtl1;
  logic [DATA_W-1:0]  slotVal0, slotVal1;
  logic [DATA_W-1:0]  regVals [NUM_REGS];
  logic [DATA_W-1:0]  rdNext;

  // plain storage registers
  for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               plainQ[g] <= '0;
      else if (strb.wrHot[g])  plainQ[g] <= busWdata;
    end
    assign regVals[g] = plainQ[g];
  end

  // raw line levels and rising detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelQ <= '0;
    else       levelQ <= irqLines;
  end
  assign riseVec = irqLines & ~levelQ;

  // pending: software value replaces, hardware rises merge on top
  always_comb begin
    pendNext = strb.wrHot[REG_INTPEND] ? (busWdata & MASK_W) : intPend;
    pendNext = pendNext | (DATA_W'(riseVec) & intEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn   <= '0;
      intPend <= '0;
      irqOut  <= 1'b0;
    end else begin
      if (strb.wrHot[REG_INTEN]) intEn <= busWdata & MASK_W;
      intPend <= pendNext;
      irqOut  <= |(intPend & intEn);
    end
  end

  // slot registers: only low control bits are writable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCtl0 <= '0;
      slotCtl1 <= '0;
    end else begin
      if (strb.wrHot[REG_SLOT0]) slotCtl0 <= busWdata[CTRL_W-1:0];
      if (strb.wrHot[REG_SLOT1]) slotCtl1 <= busWdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    slotVal0          = DATA_W'(slotCtl0);
    slotVal0[CD_BIT]  = ~levelQ[SLOT0_LINE];
    slotVal0[RDY_BIT] = 1'b1;
    slotVal1          = DATA_W'(slotCtl1);
    slotVal1[CD_BIT]  = ~levelQ[SLOT1_LINE];
    slotVal1[RDY_BIT] = 1'b1;
  end

  assign regVals[REG_INTEN]   = intEn;
  assign regVals[REG_INTPEND] = intPend;
  assign regVals[REG_SLOT0]   = slotVal0;
  assign regVals[REG_SLOT1]   = slotVal1;

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (strb.rdHot[i]) rdNext = rdNext | regVals[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdNext;
  end

  // R4
  en_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrHot[REG_INTEN] |=> intEn == ($past(busWdata) & MASK_W));

  // R3
  no_latch_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrHot[REG_INTPEND] |=> (intPend & ~$past(intPend) & ~$past(intEn)) == '0);

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrHot[REG_INTPEND] |=> (($past(intPend) & ~intPend) == '0));

  // R5
  irq_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((intPend & intEn) == '0) |=> !irqOut);

  // R5
  irq_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((intPend & intEn) != '0) |=> irqOut);

  // R6
  card_detect0_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> slotVal0[CD_BIT] == !$past(irqLines[SLOT0_LINE]));

  // R7
  slot_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrHot[REG_SLOT1] |=> slotCtl1 == $past(busWdata[CTRL_W-1:0]));

endmodule

// File: rtl/board_irq_regs.sv
module board_irq_regs
  import board_regs_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 32,
  parameter int NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_IRQ-1:0] irqLines,
  output logic               irqOut
);

  strobes_t strb;

  board_regs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb)
  );

  board_regs_data #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .irqLines (irqLines),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/board_irq_regs_test.sv
module board_irq_regs_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] irqLines = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  string curTag = "R8";
  bit done = 0;

  always #10 clk = ~clk;

  board_irq_regs uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqLines(irqLines), .irqOut(irqOut)
  );

  // reference model state
  logic [31:0] mStore [int];
  logic [31:0] mEn, mPend, mRd;
  logic [15:0] mLvl;
  logic [4:0]  mCtl0, mCtl1;
  logic        mIrq;

  function automatic bit isPlain(input logic [19:0] a);
    return a == 20'h10 || a == 20'h14 || a == 20'h40 || a == 20'h60 ||
           a == 20'h80 || a == 20'h84 || a == 20'h88 || a == 20'h90;
  endfunction

  function automatic logic [31:0] modelRead(input logic [19:0] a);
    if (isPlain(a)) return mStore.exists(int'(a)) ? mStore[int'(a)] : 32'h0;
    if (a == 20'hC0) return mEn;
    if (a == 20'hD0) return mPend;
    if (a == 20'hE0) return 32'h400 + (mLvl[9]  ? 32'h0 : 32'h20) + 32'(mCtl0);
    if (a == 20'hE4) return 32'h400 + (mLvl[13] ? 32'h0 : 32'h20) + 32'(mCtl1);
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mStore.delete();
      mEn = 0; mPend = 0; mRd = 0; mLvl = 0; mCtl0 = 0; mCtl1 = 0; mIrq = 0;
    end else begin
      logic [31:0] nPend, nEn;
      logic [15:0] rises;
      mRd  = modelRead(busAddr);
      mIrq = (mPend & mEn) != 0;
      rises = irqLines & ~mLvl;
      nEn = mEn;
      nPend = mPend;
      if (busWe) begin
        if (isPlain(busAddr)) mStore[int'(busAddr)] = busWdata;
        if (busAddr == 20'hC0) nEn = busWdata & 32'h000FEEFF;
        if (busAddr == 20'hD0) nPend = busWdata & 32'h000FEEFF;
        if (busAddr == 20'hE0) mCtl0 = busWdata[4:0];
        if (busAddr == 20'hE4) mCtl1 = busWdata[4:0];
      end
      for (int i = 0; i < 16; i++)
        if (rises[i] && mEn[i]) nPend[i] = 1'b1;
      mPend = nPend;
      mEn = nEn;
      mLvl = irqLines;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(curTag, busRdata, mRd);
      check("R5", {31'b0, irqOut}, {31'b0, mIrq});
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    busAddr = a; busWe = 1'b1; busWdata = d;
    step();
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a);
    busAddr = a;
    step(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [19:0] addrList [14];
    addrList = '{20'h10, 20'h14, 20'h40, 20'h60, 20'h80, 20'h84, 20'h88,
                 20'h90, 20'hC0, 20'hD0, 20'hE0, 20'hE4, 20'h44, 20'hD4};
    step(3);
    @(negedge clk);
    check("R8", {31'b0, irqOut}, 32'h0);
    check("R8", busRdata, 32'h0);
    step();
    rstN = 1'b1;
    // R8 reset values
    curTag = "R8";
    rd(20'hE0); rd(20'hE4); rd(20'hC0); rd(20'hD0); rd(20'h10); rd(20'h90);
    // R1 plain storage
    curTag = "R1";
    for (int i = 0; i < 8; i++) begin
      wr(addrList[i], 32'hA5000000 + 32'(i) * 32'h01010101);
      rd(addrList[i]);
    end
    // R2 write and read same address in one cycle
    curTag = "R2";
    busAddr = 20'h14; busWe = 1'b1; busWdata = 32'hDEADBEEF; step(); busWe = 1'b0; step(2);
    // R9 undefined offsets
    curTag = "R9";
    wr(20'h20, 32'hFFFFFFFF); wr(20'h12, 32'h12345678); wr(20'hFFFFC, 32'h1);
    rd(20'h20); rd(20'hFFFFC); rd(20'h12); rd(20'h10); rd(20'h14);
    // R4 masked enable and pending writes
    curTag = "R4";
    wr(20'hC0, 32'hFFFFFFFF); rd(20'hC0);
    wr(20'hD0, 32'hFFFFFFFF); rd(20'hD0);
    wr(20'hD0, 32'h0); rd(20'hD0);
    // R3 latching on rises, only when enabled
    curTag = "R3";
    wr(20'hC0, 32'h000000F0);
    irqLines = 16'h00FF; step(); rd(20'hD0);
    wr(20'hD0, 32'h0); rd(20'hD0);
    irqLines = 16'h0000; step(); irqLines = 16'h0030; step(); rd(20'hD0);
    // R4 pending write with a simultaneous rise
    curTag = "R4";
    busAddr = 20'hD0; busWe = 1'b1; busWdata = 32'h00000001; irqLines = 16'h00B0;
    step(); busWe = 1'b0; rd(20'hD0);
    wr(20'hD0, 32'h0); irqLines = 16'h0; step(); rd(20'hD0);
    // R6 card detect mirrors
    curTag = "R6";
    wr(20'hC0, 32'hFFFFFFFF);
    irqLines = 16'h0200; rd(20'hE0); rd(20'hE4);
    irqLines = 16'h2000; rd(20'hE0); rd(20'hE4);
    irqLines = 16'h0000; rd(20'hE4);
    // R7 slot writes touch only low bits
    curTag = "R7";
    wr(20'hE0, 32'hFFFFFFFF); rd(20'hE0);
    wr(20'hE4, 32'hFFFFFFEA); rd(20'hE4);
    irqLines = 16'h2200; rd(20'hE4); rd(20'hE0);
    wr(20'hD0, 32'h0);
    // R5 mixed random traffic
    curTag = "R5";
    for (int k = 0; k < 600; k++) begin
      int r;
      r = int'($urandom_range(0, 9));
      irqLines = 16'($urandom);
      busAddr = addrList[$urandom_range(0, 13)];
      busWe = (r < 2);
      if (r == 0) busAddr = 20'hD0;
      if (r == 1) busAddr = 20'hC0;
      busWdata = $urandom;
      step();
    end
    busWe = 1'b0;
    step(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule